// File: doc/BRIEF.md
# Glitch-Free System Clock Selector

This block produces the internal system clock from one of two free-running sources: the external master clock pin or the output of an on-chip frequency-locked loop. Software picks the source and, if needed, a divide-by-two of the chosen source by writing a clock control register. A second register holds two plain control bits, the loop enable and the loop oscillator enable, which are driven straight to output ports. Software is responsible for the order in which these bits are written.

A source change never produces a short pulse. The source that is currently engaged is released only on its own falling edge. The new source is engaged only after a falling edge of the new source. Between these two events the output is held low. If the old source has stopped in its low state, the switch does not complete and the output stays low. For this reason the loop must be disabled only after the master clock pin has been selected. A status output reports that a switch has been requested and has not yet completed. A synchronous soft reset clears both registers, which selects the master clock pin again.

Top module: `sysclk_select`

## Requirements
- R1: After reset both registers are zero. The loop enable and oscillator enable outputs are 0, and once the master clock leg has engaged, `sysClkOut` follows `mclkIn` undivided.
- R2: A write to address 0x28 takes bit 11 as the source select (0 = master clock pin, 1 = loop output) and bit 8 as the divide select (0 = undivided, 1 = divide by two). A write to any other address leaves both bits unchanged.
- R3: A write to address 0x2A takes bit 0 as the loop enable and bit 1 as the oscillator enable. Both appear on `fllEnOut` and `fllOscEnOut` at the clock edge of the write. A write to any other address leaves them unchanged.
- R4: Once a switch has completed, the period of `sysClkOut` equals the period of the selected source, or twice that period when the divide select is 1.
- R5: `switchPending` reads 1 from the clock edge of a write that changes the source select. It returns to 0 only after the new source is engaged. While it reads 0, the selected source's leg is engaged.
- R6: If the old source has stopped low when a switch is requested, the switch does not complete. `sysClkOut` stays low and `switchPending` stays 1. When the old source runs again, the switch completes.
- R7: The two source legs are never engaged at the same time. No high or low pulse on `sysClkOut` is shorter than half the period of the faster source, including during switches and divide changes.
- R8: A soft reset pulse clears the source select, the divide select, the loop enable and the oscillator enable at the next clock edge. The output then returns to the undivided master clock pin.
- R9: With the divide select at 1, the high and low times of `sysClkOut` are each one full period of the selected source (50% duty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and status clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register write address |
| regWrData | input | 16 | Register write data |
| softRst | input | 1 | Synchronous soft reset pulse |
| mclkIn | input | 1 | Master clock pin source |
| fllClkIn | input | 1 | Frequency-locked loop output source |
| sysClkOut | output | 1 | Selected, optionally divided system clock |
| fllEnOut | output | 1 | Loop enable bit |
| fllOscEnOut | output | 1 | Loop oscillator enable bit |
| switchPending | output | 1 | Source switch requested, not yet complete |

## Verification
The bench builds the block with its default parameters: two-stage synchronizers, the control register at 0x28 with select on bit 11 and divide on bit 8, and the loop control register at 0x2A. The master clock is driven at 38 ns and the loop clock at 26 ns. These unrelated periods make every switch land at a varying phase between the two sources. Together with the two-stage depth, this brings the release/engage handshake, the low hold between legs and the divide-phase alignment within reach of a pulse-width monitor whose bound is 13 ns. The same parameters let the bench stop the loop clock in its low state and observe a stalled switch, then restart it.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  localparam int NUM_SRC  = 2;
  localparam int SRC_MCLK = 0;
  localparam int SRC_FLL  = 1;

  // strobes from the register side to the clock datapath
  typedef struct packed {
    logic selFll;
    logic divTwo;
  } clkCtrl_t;

endpackage

// File: rtl/sysclk_gate_leg.sv
// One source leg: requests are sampled on the falling edge of the leg's own
// clock through a synchronizer chain; the chain end is the leg enable.
module sysclk_gate_leg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic srcClk,
  input  logic rstN,
  input  logic req,
  output logic en
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;

  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], req};
    end
  end

  assign en = syncChain[LAST];

endmodule

// File: rtl/sysclk_div2.sv
// Optional divide-by-two after the source mux. The divide choice is resynchronised
// to the muxed clock and applied only on a falling edge while the toggle flop is low,
// so the change happens with the output low on both sides.
module sysclk_div2 #(
  parameter int SYNC_STAGES = 2
) (
  input  logic muxClk,
  input  logic rstN,
  input  logic divReq,
  output logic clkOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] divSync;
  logic                   toggleQ;
  logic                   divApplied;

  always_ff @(negedge muxClk or negedge rstN) begin
    if (!rstN) begin
      divSync <= '0;
    end else begin
      divSync <= {divSync[SYNC_STAGES-2:0], divReq};
    end
  end

  always_ff @(posedge muxClk or negedge rstN) begin
    if (!rstN) begin
      toggleQ <= 1'b0;
    end else begin
      toggleQ <= ~toggleQ;
    end
  end

  always_ff @(negedge muxClk or negedge rstN) begin
    if (!rstN) begin
      divApplied <= 1'b0;
    end else if (!toggleQ && (divSync[LAST] != divApplied)) begin
      divApplied <= divSync[LAST];
    end
  end

  assign clkOut = divApplied ? toggleQ : muxClk;

endmodule

// File: rtl/sysclk_datapath.sv
module sysclk_datapath
  import sysclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               mclkIn,
  input  logic               fllClkIn,
  input  logic               rstN,
  input  clkCtrl_t           ctrlBus,
  output logic               sysClk,
  output logic [NUM_SRC-1:0] enVec
);

  logic [NUM_SRC-1:0] srcClk;
  logic [NUM_SRC-1:0] wantSrc;
  logic [NUM_SRC-1:0] legReq;
  logic               muxClk;

  assign srcClk[SRC_MCLK]  = mclkIn;
  assign srcClk[SRC_FLL]   = fllClkIn;
  assign wantSrc[SRC_MCLK] = ~ctrlBus.selFll;
  assign wantSrc[SRC_FLL]  = ctrlBus.selFll;

  // cross-coupled legs: a leg may only request while the other is released
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
    assign legReq[i] = wantSrc[i] & ~enVec[NUM_SRC-1-i];

    sysclk_gate_leg #(
      .SYNC_STAGES(SYNC_STAGES)
    ) leg_i (
      .srcClk(srcClk[i]),
      .rstN  (rstN),
      .req   (legReq[i]),
      .en    (enVec[i])
    );
  end

  assign muxClk = |(srcClk & enVec);

  sysclk_div2 #(
    .SYNC_STAGES(SYNC_STAGES)
  ) div_i (
    .muxClk(muxClk),
    .rstN  (rstN),
    .divReq(ctrlBus.divTwo),
    .clkOut(sysClk)
  );

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int CLKCTL_ADDR = 'h28,
  parameter int SEL_BIT     = 11,
  parameter int DIV_BIT     = 8,
  parameter int FLLCTL_ADDR = 'h2A,
  parameter int FLL_EN_BIT  = 0,
  parameter int OSC_EN_BIT  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               softRst,
  input  logic [NUM_SRC-1:0] enVec,
  output clkCtrl_t           ctrlBus,
  output logic               fllEn,
  output logic               fllOscEn,
  output logic               pending
);

  localparam logic [ADDR_W-1:0] CLK_ADDR = ADDR_W'(CLKCTL_ADDR);
  localparam logic [ADDR_W-1:0] FLL_ADDR = ADDR_W'(FLLCTL_ADDR);
  localparam int                LAST     = SYNC_STAGES - 1;

  logic                   clkCtlHit;
  logic                   fllCtlHit;
  logic [SYNC_STAGES-1:0] enSync [NUM_SRC];
  logic                   unusedDataBits;

  assign clkCtlHit      = regWrEn && (regAddr == CLK_ADDR);
  assign fllCtlHit      = regWrEn && (regAddr == FLL_ADDR);
  assign unusedDataBits = ^regWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlBus <= '0;
    end else if (softRst) begin
      ctrlBus <= '0;
    end else if (clkCtlHit) begin
      ctrlBus.selFll <= regWrData[SEL_BIT];
      ctrlBus.divTwo <= regWrData[DIV_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fllEn    <= 1'b0;
      fllOscEn <= 1'b0;
    end else if (softRst) begin
      fllEn    <= 1'b0;
      fllOscEn <= 1'b0;
    end else if (fllCtlHit) begin
      fllEn    <= regWrData[FLL_EN_BIT];
      fllOscEn <= regWrData[OSC_EN_BIT];
    end
  end

  // leg enables brought into the register clock domain
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enSync[i] <= '0;
      end else begin
        enSync[i] <= {enSync[i][SYNC_STAGES-2:0], enVec[i]};
      end
    end
  end

  assign pending = ctrlBus.selFll ? !enSync[SRC_FLL][LAST] : !enSync[SRC_MCLK][LAST];

endmodule

// File: rtl/sysclk_select.sv
module sysclk_select
  import sysclk_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int CLKCTL_ADDR = 'h28,
  parameter int SEL_BIT     = 11,
  parameter int DIV_BIT     = 8,
  parameter int FLLCTL_ADDR = 'h2A,
  parameter int FLL_EN_BIT  = 0,
  parameter int OSC_EN_BIT  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              softRst,
  input  logic              mclkIn,
  input  logic              fllClkIn,
  output logic              sysClkOut,
  output logic              fllEnOut,
  output logic              fllOscEnOut,
  output logic              switchPending
);

  clkCtrl_t           ctrlBus;
  logic [NUM_SRC-1:0] enVec;

  sysclk_ctrl #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CLKCTL_ADDR(CLKCTL_ADDR),
    .SEL_BIT    (SEL_BIT),
    .DIV_BIT    (DIV_BIT),
    .FLLCTL_ADDR(FLLCTL_ADDR),
    .FLL_EN_BIT (FLL_EN_BIT),
    .OSC_EN_BIT (OSC_EN_BIT),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .softRst  (softRst),
    .enVec    (enVec),
    .ctrlBus  (ctrlBus),
    .fllEn    (fllEnOut),
    .fllOscEn (fllOscEnOut),
    .pending  (switchPending)
  );

  sysclk_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .mclkIn  (mclkIn),
    .fllClkIn(fllClkIn),
    .rstN    (rstN),
    .ctrlBus (ctrlBus),
    .sysClk  (sysClkOut),
    .enVec   (enVec)
  );

endmodule

// File: rtl/sysclk_select_chk.sv
module sysclk_select_chk
  import sysclk_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int CLKCTL_ADDR = 'h28,
  parameter int SEL_BIT     = 11,
  parameter int DIV_BIT     = 8,
  parameter int FLLCTL_ADDR = 'h2A,
  parameter int FLL_EN_BIT  = 0,
  parameter int OSC_EN_BIT  = 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic               softRst,
  input logic               fllEnOut,
  input logic               fllOscEnOut,
  input logic               switchPending,
  input clkCtrl_t           ctrlBus,
  input logic [NUM_SRC-1:0] enVec
);

  localparam logic [ADDR_W-1:0] CLK_ADDR = ADDR_W'(CLKCTL_ADDR);
  localparam logic [ADDR_W-1:0] FLL_ADDR = ADDR_W'(FLLCTL_ADDR);

  a_r2_sel_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == CLK_ADDR && !softRst)
      |=> (ctrlBus.selFll == $past(regWrData[SEL_BIT]) && ctrlBus.divTwo == $past(regWrData[DIV_BIT])));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWrEn && regAddr == CLK_ADDR) && !softRst) |=> $stable(ctrlBus));

  a_r3_fll_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == FLL_ADDR && !softRst)
      |=> (fllEnOut == $past(regWrData[FLL_EN_BIT]) && fllOscEnOut == $past(regWrData[OSC_EN_BIT])));

  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!ctrlBus.selFll && !ctrlBus.divTwo && !fllEnOut && !fllOscEnOut));

  a_r7_legs_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(enVec));

  a_r5_idle_means_engaged: assert property (@(posedge clk) disable iff (!rstN)
    !switchPending |-> enVec[ctrlBus.selFll]);

endmodule

bind sysclk_select sysclk_select_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .CLKCTL_ADDR(CLKCTL_ADDR),
  .SEL_BIT    (SEL_BIT),
  .DIV_BIT    (DIV_BIT),
  .FLLCTL_ADDR(FLLCTL_ADDR),
  .FLL_EN_BIT (FLL_EN_BIT),
  .OSC_EN_BIT (OSC_EN_BIT)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regAddr      (regAddr),
  .regWrData    (regWrData),
  .softRst      (softRst),
  .fllEnOut     (fllEnOut),
  .fllOscEnOut  (fllOscEnOut),
  .switchPending(switchPending),
  .ctrlBus      (ctrlBus),
  .enVec        (enVec)
);

// File: tb/sysclk_select_tb_top.sv
`timescale 1ns/1ps
module sysclk_select_tb_top;

  localparam real MCLK_HALF = 19.0;
  localparam real FLL_HALF  = 13.0;
  localparam real MIN_PULSE = 13.0;   // half period of the faster source

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic        softRst = 1'b0;
  logic        mclkIn = 1'b0;
  logic        fllClkIn = 1'b0;
  logic        sysClkOut;
  logic        fllEnOut;
  logic        fllOscEnOut;
  logic        switchPending;

  logic        fllRun = 1'b1;
  logic        monOn = 1'b0;
  logic        done = 1'b0;
  int          nChecks = 0;
  int          nFails = 0;
  int          nShort = 0;
  realtime     lastEdge = -1.0;
  logic        curSel = 1'b0;

  sysclk_select dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .softRst      (softRst),
    .mclkIn       (mclkIn),
    .fllClkIn     (fllClkIn),
    .sysClkOut    (sysClkOut),
    .fllEnOut     (fllEnOut),
    .fllOscEnOut  (fllOscEnOut),
    .switchPending(switchPending)
  );

  always #5 clk = ~clk;
  initial forever #(MCLK_HALF) mclkIn = ~mclkIn;
  initial forever begin
    #(FLL_HALF);
    if (fllRun || fllClkIn) fllClkIn = ~fllClkIn;   // stops only in the low state
  end

  // R7 pulse-width monitor
  always @(sysClkOut) begin
    if (monOn) begin
      if (lastEdge >= 0.0 && ($realtime - lastEdge) < MIN_PULSE - 0.01) begin
        nShort++;
        $display("FAIL R7 pulse width actual %0.3f ns expected >= %0.3f ns at %0t",
                 $realtime - lastEdge, MIN_PULSE, $time);
      end
      lastEdge = $realtime;
    end
  end

  function automatic real expPeriod(input logic sel, input logic div);
    real p;
    p = sel ? 2.0 * FLL_HALF : 2.0 * MCLK_HALF;
    return div ? 2.0 * p : p;
  endfunction

  task automatic check(input string req, input logic ok, input real act, input real exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 300 && switchPending; i++) @(negedge clk);
  endtask

  task automatic measure(output real per, output real hi);
    realtime t0, t1, t2;
    repeat (10) @(posedge sysClkOut);
    @(posedge sysClkOut); t0 = $realtime;
    @(negedge sysClkOut); t1 = $realtime;
    @(posedge sysClkOut); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic checkClock(input string req, input logic sel, input logic div);
    real per, hi, e;
    measure(per, hi);
    e = expPeriod(sel, div);
    check(req, (per > e - 0.01) && (per < e + 0.01), per, e);
    if (div) check("R9 duty", (hi > e / 2.0 - 0.01) && (hi < e / 2.0 + 0.01), hi, e / 2.0);
  endtask

  task automatic selectClock(input string req, input logic sel, input logic div,
                             input logic [15:0] noise);
    logic [15:0] d;
    d = noise & ~16'h0900;
    d[11] = sel;
    d[8]  = div;
    regWrite(8'h28, d);
    if (sel != curSel)
      check({req, " R5 pending set"}, switchPending == 1'b1, real'(switchPending), 1.0);
    curSel = sel;
    waitIdle();
    check({req, " R5 pending clear"}, switchPending == 1'b0, real'(switchPending), 0.0);
    checkClock({req, " R4 period"}, sel, div);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 fllEn", fllEnOut == 1'b0, real'(fllEnOut), 0.0);
    check("R1 oscEn", fllOscEnOut == 1'b0, real'(fllOscEnOut), 0.0);
    waitIdle();
    check("R1 pending", switchPending == 1'b0, real'(switchPending), 0.0);
    checkClock("R1 default mclk", 1'b0, 1'b0);

    // R3 loop control bits, software order: oscillator then loop
    regWrite(8'h2A, 16'h0002);
    check("R3 osc set", fllOscEnOut == 1'b1, real'(fllOscEnOut), 1.0);
    check("R3 fll still off", fllEnOut == 1'b0, real'(fllEnOut), 0.0);
    regWrite(8'h2A, 16'h0003);
    check("R3 fll set", fllEnOut == 1'b1, real'(fllEnOut), 1.0);
    regWrite(8'h28, 16'h0000);   // R3 other address ignored
    check("R3 ignore other addr", fllEnOut == 1'b1 && fllOscEnOut == 1'b1,
          real'({fllEnOut, fllOscEnOut}), 3.0);
    waitIdle();

    // R2 other address ignored
    regWrite(8'h27, 16'hFFFF);
    check("R2 ignore other addr", switchPending == 1'b0, real'(switchPending), 0.0);
    checkClock("R2 still mclk undivided", 1'b0, 1'b0);

    // directed switches
    selectClock("R2 to fll", 1'b1, 1'b0, 16'h0000);
    selectClock("R2 fll div", 1'b1, 1'b1, 16'h0000);
    selectClock("R2 mclk div", 1'b0, 1'b1, 16'h0000);

    // constrained random source / divide changes with noise in other bits
    for (int k = 0; k < 14; k++) begin
      logic s, v;
      s = 1'($urandom % 2);
      v = 1'($urandom % 2);
      selectClock("R4 random", s, v, 16'($urandom));
    end

    // R6 stalled switch: loop selected, loop stops low, then mclk requested
    selectClock("R6 setup", 1'b1, 1'b0, 16'h0000);
    fllRun = 1'b0;
    repeat (10) @(negedge clk);
    regWrite(8'h28, 16'h0000);
    curSel = 1'b0;
    begin
      logic sawHigh;
      sawHigh = 1'b0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (sysClkOut) sawHigh = 1'b1;
      end
      check("R6 output held low", sawHigh == 1'b0, real'(sawHigh), 0.0);
      check("R6 pending held", switchPending == 1'b1, real'(switchPending), 1.0);
    end
    fllRun = 1'b1;
    waitIdle();
    check("R6 completes after restart", switchPending == 1'b0, real'(switchPending), 0.0);
    checkClock("R6 mclk after restart", 1'b0, 1'b0);

    // R8 soft reset from loop source, divided, control bits set
    regWrite(8'h2A, 16'h0003);
    selectClock("R8 setup", 1'b1, 1'b1, 16'h0000);
    @(negedge clk);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    check("R8 fllEn cleared", fllEnOut == 1'b0, real'(fllEnOut), 0.0);
    check("R8 oscEn cleared", fllOscEnOut == 1'b0, real'(fllOscEnOut), 0.0);
    check("R8 switch back requested", switchPending == 1'b1, real'(switchPending), 1.0);
    curSel = 1'b0;
    waitIdle();
    checkClock("R8 mclk undivided", 1'b0, 1'b0);

    // R7 pulse monitor result
    check("R7 no short pulse", nShort == 0, real'(nShort), 0.0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule